// File: doc/BRIEF.md
# Coded Reference Frequency Divider

This block divides a reference clock (a crystal oscillator or an external source) down to the comparison frequency used by a phase detector. The ratio is chosen by a 5-bit code. The upper two bits pick a multiplier family: binary 2, ×5, ×6 or ×7. The lower three bits pick a power-of-two exponent. Together they give 29 legal ratios from 2 up to 448. The three codes that pair a non-binary family with exponent zero are illegal. When one of them is applied, a flag goes high and the last legal ratio stays in force.

The divided frequency comes out in two forms. The first is a pulse that is high for one reference cycle per output period; it is meant for the phase detector. The second is a square wave that toggles on every pulse, so it runs at half the comparison rate with an even duty cycle; it is meant for routing onto a test port.

A down-counter sequenced by a three-state machine produces the output period:
- ST_START is entered from reset. It preloads the counter and always moves to ST_RUN.
- ST_RUN decrements the counter. While the counter is non-zero it stays in ST_RUN; when the counter is zero it moves to ST_TERM.
- ST_TERM is the terminal cycle. It drives the pulse, reloads the counter from the held ratio and always returns to ST_RUN.

A new code is therefore picked up only at a terminal count.

Top module: `fcomp_divider`

## Requirements
- R1: While `rst_n` is low, `fcomp_pulse`, `fcomp_square` and `code_illegal` are all 0.
- R2: When `ratio_code[4:3]` is 00, the output period is 2^(`ratio_code[2:0]`+1) reference cycles. This covers 2, 4, 8, 16, 32, 64, 128 and 256.
- R3: When `ratio_code[4:3]` is 01, 10 or 11 (multipliers 5, 6 and 7) and `ratio_code[2:0]` is non-zero, the period is the multiplier times 2^(`ratio_code[2:0]`-1). This covers 5 to 320, 6 to 384 and 7 to 448.
- R4: Codes 01000, 10000 and 11000 are illegal. `code_illegal` is registered: it shows whether the code sampled at the previous clock edge was illegal.
- R5: While an illegal code is applied, the ratio that was in force before it keeps being used.
- R6: `fcomp_pulse` is high for exactly one reference cycle in each output period.
- R7: A code change takes effect only at the next terminal count. The period already in progress finishes at its old length, and the period after the next pulse uses the new ratio.
- R8: `fcomp_square` inverts in the cycle after each pulse and holds its value at all other times. Its period is therefore twice the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 5 | Ratio code: [4:3] multiplier family, [2:0] exponent |
| fcomp_pulse | output | 1 | One-cycle pulse at the comparison frequency |
| fcomp_square | output | 1 | Toggles on each pulse; used for test routing |
| code_illegal | output | 1 | Registered flag: the last sampled code was illegal |

## Verification
The assertions expect `rst_n` to be low at the first clock edge. They place no constraint on `ratio_code`, which may take any of its 32 values and may change on any cycle, including during a count. The bench drives the code only at falling edges. It usually changes the code right after an observed pulse, so that each measured gap can be attributed either to the old ratio or to the new one. One directed case changes the code in the middle of a 448-cycle period to show that the change waits for the terminal count. The ratio is never taken below 2, the smallest period the counter sequence supports.

// File: rtl/fcdiv_pkg.sv
package fcdiv_pkg;

    localparam int CODE_W    = 5;
    localparam int FAM_W     = 2;
    localparam int EXP_W     = 3;
    localparam int MAX_MULT  = 7;
    localparam int MAX_RATIO = MAX_MULT << ((1 << EXP_W) - 2);
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);
    localparam int MIN_RATIO = 2;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef enum logic [FAM_W-1:0] {
        FAM_BIN = 2'd0,
        FAM_X5  = 2'd1,
        FAM_X6  = 2'd2,
        FAM_X7  = 2'd3
    } family_t;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_RUN   = 2'd1,
        ST_TERM  = 2'd2
    } div_state_t;

endpackage

// File: rtl/fcdiv_decode.sv
module fcdiv_decode
    import fcdiv_pkg::*;
#(
    parameter int C_W = CODE_W,
    parameter int F_W = FAM_W,
    parameter int E_W = EXP_W,
    parameter int R_W = RATIO_W
) (
    input  logic [C_W-1:0] code,
    output logic [R_W-1:0] ratio,
    output logic           legal
);

    localparam logic [R_W-1:0] BIN_MANT  = R_W'(2);
    localparam logic [R_W-1:0] MULT_BASE = R_W'(4);
    localparam logic [E_W-1:0] ONE_EXP   = E_W'(1);

    family_t          fam;
    logic [E_W-1:0]   expo;
    logic [R_W-1:0]   mant;
    logic [E_W-1:0]   shamt;

    always_comb begin
        fam  = family_t'(code[C_W-1 -: F_W]);
        expo = code[E_W-1:0];
        unique case (fam)
            FAM_BIN: begin
                mant  = BIN_MANT;
                shamt = expo;
                legal = 1'b1;
            end
            FAM_X5, FAM_X6, FAM_X7: begin
                mant  = MULT_BASE + R_W'(fam);
                legal = (expo != '0);
                shamt = legal ? (expo - ONE_EXP) : '0;
            end
            default: begin
                mant  = BIN_MANT;
                shamt = '0;
                legal = 1'b0;
            end
        endcase
        ratio = mant << shamt;
    end

endmodule

// File: rtl/fcdiv_hold.sv
module fcdiv_hold
    import fcdiv_pkg::*;
#(
    parameter int R_W       = RATIO_W,
    parameter int RST_RATIO = MIN_RATIO
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] ratio_in,
    input  logic           legal_in,
    output logic [R_W-1:0] held_ratio,
    output logic           bad
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_ratio <= R_W'(RST_RATIO);
            bad        <= 1'b0;
        end else begin
            bad <= !legal_in;
            if (legal_in) begin
                held_ratio <= ratio_in;
            end
        end
    end

    // R4: flag follows the legality of the code sampled one edge earlier
    a_r4_flag_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_in |=> bad);
    a_r4_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        legal_in |=> !bad);
    // R5: illegal code leaves the ratio in force untouched
    a_r5_ratio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_in |=> $stable(held_ratio));

endmodule

// File: rtl/fcdiv_count.sv
module fcdiv_count
    import fcdiv_pkg::*;
#(
    parameter int R_W = RATIO_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] ratio,
    output logic           pulse
);

    localparam logic [R_W-1:0] PRELOAD_OFS = R_W'(2);
    localparam logic [R_W-1:0] STEP        = R_W'(1);

    div_state_t     state, nxt;
    logic [R_W-1:0] cnt;
    logic           load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_START;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        unique case (state)
            ST_START: nxt = ST_RUN;
            ST_RUN:   nxt = (cnt == '0) ? ST_TERM : ST_RUN;
            ST_TERM:  nxt = ST_RUN;
            default:  nxt = ST_START;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        unique case (state)
            ST_START: begin pulse = 1'b0; load = 1'b1; end
            ST_RUN:   begin pulse = 1'b0; load = 1'b0; end
            ST_TERM:  begin pulse = 1'b1; load = 1'b1; end
            default:  begin pulse = 1'b0; load = 1'b1; end
        endcase
    end

    // down-counter: preload ratio-2 so START/TERM plus RUN span the ratio
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= ratio - PRELOAD_OFS;
        end else if (cnt != '0) begin
            cnt <= cnt - STEP;
        end
    end

    // R6: pulse never lasts two cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    // R7: reload happens only in the terminal cycle, from the ratio seen there
    a_r7_reload_at_term: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TERM) |=> (cnt == $past(ratio) - PRELOAD_OFS));
    a_r7_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cnt != '0) |=> (cnt == $past(cnt) - STEP));

endmodule

// File: rtl/fcomp_divider.sv
module fcomp_divider
    import fcdiv_pkg::*;
#(
    parameter int C_W = CODE_W,
    parameter int R_W = RATIO_W
) (
    input  logic           ref_clk,
    input  logic           rst_n,
    input  logic [C_W-1:0] ratio_code,
    output logic           fcomp_pulse,
    output logic           fcomp_square,
    output logic           code_illegal
);

    logic [R_W-1:0] dec_ratio;
    logic           dec_legal;
    logic [R_W-1:0] use_ratio;

    fcdiv_decode #(.C_W(C_W), .F_W(FAM_W), .E_W(EXP_W), .R_W(R_W)) u_decode (
        .code  (ratio_code),
        .ratio (dec_ratio),
        .legal (dec_legal)
    );

    fcdiv_hold #(.R_W(R_W), .RST_RATIO(MIN_RATIO)) u_hold (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .ratio_in   (dec_ratio),
        .legal_in   (dec_legal),
        .held_ratio (use_ratio),
        .bad        (code_illegal)
    );

    fcdiv_count #(.R_W(R_W)) u_count (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .ratio (use_ratio),
        .pulse (fcomp_pulse)
    );

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            fcomp_square <= 1'b0;
        end else if (fcomp_pulse) begin
            fcomp_square <= !fcomp_square;
        end
    end

    // R2: binary family decodes to a single power of two
    a_r2_binary_family: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (ratio_code[C_W-1 -: FAM_W] == '0) |-> (dec_legal && $countones(dec_ratio) == 1));
    // R3: every legal decode lies inside the supported range
    a_r3_ratio_bounds: assert property (@(posedge ref_clk) disable iff (!rst_n)
        dec_legal |-> (dec_ratio >= R_W'(MIN_RATIO) && dec_ratio <= R_W'(MAX_RATIO)));
    // R8: square output flips after a pulse and is steady otherwise
    a_r8_square_flip: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fcomp_pulse |=> (fcomp_square != $past(fcomp_square)));
    a_r8_square_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !fcomp_pulse |=> $stable(fcomp_square));

endmodule

// File: tb/fcomp_divider_test.sv
module fcomp_divider_test;

    typedef struct packed {
        logic [4:0] code;
        logic [9:0] ratio;
        logic       bad;
    } vec_t;

    // expected ratio per code; illegal rows keep the ratio of the row before
    localparam vec_t VECS [32] = '{
        '{5'd0,  10'd2,   1'b0}, '{5'd1,  10'd4,   1'b0},
        '{5'd2,  10'd8,   1'b0}, '{5'd3,  10'd16,  1'b0},
        '{5'd4,  10'd32,  1'b0}, '{5'd5,  10'd64,  1'b0},
        '{5'd6,  10'd128, 1'b0}, '{5'd7,  10'd256, 1'b0},
        '{5'd8,  10'd256, 1'b1}, '{5'd9,  10'd5,   1'b0},
        '{5'd10, 10'd10,  1'b0}, '{5'd11, 10'd20,  1'b0},
        '{5'd12, 10'd40,  1'b0}, '{5'd13, 10'd80,  1'b0},
        '{5'd14, 10'd160, 1'b0}, '{5'd15, 10'd320, 1'b0},
        '{5'd16, 10'd320, 1'b1}, '{5'd17, 10'd6,   1'b0},
        '{5'd18, 10'd12,  1'b0}, '{5'd19, 10'd24,  1'b0},
        '{5'd20, 10'd48,  1'b0}, '{5'd21, 10'd96,  1'b0},
        '{5'd22, 10'd192, 1'b0}, '{5'd23, 10'd384, 1'b0},
        '{5'd24, 10'd384, 1'b1}, '{5'd25, 10'd7,   1'b0},
        '{5'd26, 10'd14,  1'b0}, '{5'd27, 10'd28,  1'b0},
        '{5'd28, 10'd56,  1'b0}, '{5'd29, 10'd112, 1'b0},
        '{5'd30, 10'd224, 1'b0}, '{5'd31, 10'd448, 1'b0}
    };

    logic       clk;
    logic       rst_n;
    logic [4:0] code;
    logic       pulse;
    logic       square;
    logic       illegal;

    int total;
    int bad;
    int prev_ratio;

    fcomp_divider uut (
        .ref_clk      (clk),
        .rst_n        (rst_n),
        .ratio_code   (code),
        .fcomp_pulse  (pulse),
        .fcomp_square (square),
        .code_illegal (illegal)
    );

    initial clk = 1'b0;
    always #5 clk = !clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts cycles from the current negedge to the next pulse
    task automatic meas(input bit chk_sq, output int n);
        logic sq0;
        sq0 = square;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1 && chk_sq) begin
                check(square != sq0, "R8 square flip", int'(square), int'(!sq0));
                check(!pulse, "R6 pulse width", int'(pulse), 0);
            end
        end while (!pulse && n < 2000);
    endtask

    initial begin
        int g;
        total = 0;
        bad = 0;
        rst_n = 1'b0;
        code = 5'd0;
        repeat (3) @(negedge clk);
        check(!pulse, "R1 pulse in reset", int'(pulse), 0);
        check(!square, "R1 square in reset", int'(square), 0);
        check(!illegal, "R1 flag in reset", int'(illegal), 0);
        rst_n = 1'b1;
        meas(1'b0, g);
        meas(1'b1, g);
        check(g == 2, "R2 startup ratio", g, 2);
        prev_ratio = 2;

        // table walk: code applied right after a pulse
        for (int i = 0; i < 32; i++) begin
            string tag;
            code = VECS[i].code;
            meas(1'b1, g);
            check(g == prev_ratio, "R7 old period kept", g, prev_ratio);
            check(illegal == VECS[i].bad, "R4 illegal flag", int'(illegal), int'(VECS[i].bad));
            meas(1'b1, g);
            tag = VECS[i].bad ? "R5 hold on illegal" :
                  (VECS[i].code[4:3] == 2'b00 ? "R2 binary ratio" : "R3 multiplied ratio");
            check(g == int'(VECS[i].ratio), tag, g, int'(VECS[i].ratio));
            prev_ratio = int'(VECS[i].ratio);
        end

        // change in the middle of a 448 period
        repeat (100) @(negedge clk);
        code = 5'd1;
        meas(1'b0, g);
        check(g + 100 == 448, "R7 mid-period change", g + 100, 448);
        meas(1'b1, g);
        check(g == 4, "R7 new ratio after term", g, 4);

        // illegal directly after a short ratio, then recover
        code = 5'b01000;
        meas(1'b1, g);
        check(illegal, "R4 flag on 01000", int'(illegal), 1);
        meas(1'b1, g);
        check(g == 4, "R5 ratio held", g, 4);
        code = 5'b01001;
        @(negedge clk);
        check(!illegal, "R4 flag clears", int'(illegal), 0);
        meas(1'b0, g);
        meas(1'b1, g);
        check(g == 5, "R3 ratio 5 after recovery", g, 5);

        // reset in the middle of a run
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!pulse && !square && !illegal, "R1 mid-run reset",
              int'({pulse, square, illegal}), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule